// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block owns the status register of a 1 MB serial NOR flash and decides whether each write-type command may run. It receives already-decoded command strobes (an opcode byte with a 20-bit target address), the level of the write-protect pin, the data byte that goes with a status register write, and a completion pulse from the erase/program engines. It answers every write-type strobe with a one-cycle grant or reject, and it shows the status byte for reads.

The controller keeps a write-enable latch, a three-bit block-protect level that fences off a region at the top of the address space, and a status-lock bit. The status lock blocks status writes only while the write-protect pin is held low. A granted operation holds the busy flag until the completion pulse arrives. At that point the latch clears, and for a status write the new protect settings take effect.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 00h and neither grant nor reject is asserted.
- R2: When not busy, opcode 06h sets the write-enable latch (status bit 1) and opcode 04h clears it. Both opcodes are ignored while busy.
- R3: The write-type opcodes are 02h (page program), 20h (small sector erase), D8h (sector erase), C7h (chip erase) and 01h (status write). Each strobe of one of them is answered by exactly one of grant or reject, as a single-cycle pulse in the cycle after the strobe. Any other opcode produces neither pulse and changes no status bit.
- R4: The protect level is status bits 4:2. The protected region is: 000 none, 001 F0000h–FFFFFh, 010 E0000h–FFFFFh, 011 C0000h–FFFFFh, 100 80000h–FFFFFh, and 101/110/111 the whole array.
- R5: A program or either sector erase is granted only when the latch is 1, the block is not busy and the address lies outside the protected region.
- R6: Chip erase is granted only when the latch is 1, the block is not busy and the protect level is 000. The address is not used.
- R7: A status write is granted only when the latch is 1 and the block is not busy, and it is rejected when status bit 7 is 1 while the write-protect pin is low. With the pin high, bit 7 has no effect.
- R8: A rejected request leaves the latch and every other status bit unchanged.
- R9: Status bit 0 (busy) rises with the grant and falls in the cycle after the completion pulse. Write-type requests made while busy are rejected. A completion pulse while idle has no effect.
- R10: On completion the latch clears. For a status write, bits 4:2 and 7 load from the data byte captured at the request, and they change only at completion.
- R11: Status bits 6:5 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command strobe, one cycle |
| req_op | input | 8 | Opcode of the command |
| req_addr | input | 20 | Target byte address |
| wp_pin | input | 1 | Write-protect pin level (0 = low, lock may apply) |
| sr_wdata | input | 8 | Data byte for a status write |
| op_done | input | 1 | Completion pulse from the operation engines |
| grant | output | 1 | Request accepted, one-cycle pulse |
| reject | output | 1 | Request refused, one-cycle pulse |
| status | output | 8 | Status byte {lock, 0, 0, protect[2:0], latch, busy} |

## Verification
The assertions check on every cycle that the two verdicts never coincide, that every write-type strobe gets its answer one cycle later, that a grant always shows busy, and that completion clears both busy and the latch. They also check that protect bits move only on completion, that reserved bits stay zero, and that a locked status write and a chip erase under a non-zero level are refused. The address-to-region mapping at each protect level, the capture of the data byte at request time, and the interplay of random command streams with completion pulses can only be shown by the bench's scenarios, which compare against a reference model.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_WREN,
        K_WRDI,
        K_PROG,
        K_ERASE,
        K_CHIP,
        K_SRW
    } cmd_kind_e;

    typedef struct packed {
        logic grant;
        logic reject;
    } verdict_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SSE   = 8'h20;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_CHIP  = 8'hC7;
    localparam logic [7:0] OP_SRW   = 8'h01;

    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_LOCK = 7;

    // bits a status write may change: lock and protect level
    localparam logic [7:0] SR_WMASK = 8'b1001_1100;

    function automatic cmd_kind_e decode_op(input logic [7:0] op);
        case (op)
            OP_WREN:       return K_WREN;
            OP_WRDI:       return K_WRDI;
            OP_PROG:       return K_PROG;
            OP_SSE, OP_SE: return K_ERASE;
            OP_CHIP:       return K_CHIP;
            OP_SRW:        return K_SRW;
            default:       return K_NONE;
        endcase
    endfunction

    function automatic logic is_write_kind(input cmd_kind_e k);
        return (k == K_PROG) || (k == K_ERASE) || (k == K_CHIP) || (k == K_SRW);
    endfunction

endpackage

// File: rtl/flash_wp_region.sv
module flash_wp_region #(
    parameter int ADDR_W = 20,
    parameter int LEVELS = 4
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int SHIFT0 = ADDR_W - LEVELS - 1;

    logic [ADDR_W-1:0] bound [1:LEVELS];

    // lower edge of the fenced region for each partial level
    for (genvar g = 1; g <= LEVELS; g++) begin : g_bound
        assign bound[g] = {ADDR_W{1'b1}} << (SHIFT0 + g);
    end

    always_comb begin
        unique case (bp)
            3'd0:    hit = 1'b0;
            3'd1:    hit = addr >= bound[1];
            3'd2:    hit = addr >= bound[2];
            3'd3:    hit = addr >= bound[3];
            3'd4:    hit = addr >= bound[4];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/flash_wp_decide.sv
module flash_wp_decide
    import flash_wp_pkg::*;
(
    input  cmd_kind_e  kind,
    input  logic       busy,
    input  logic       wel,
    input  logic       lock,
    input  logic [2:0] bp,
    input  logic       wp_pin,
    input  logic       hit,
    output verdict_t   verdict
);
    logic allowed;

    always_comb begin
        unique case (kind)
            K_PROG, K_ERASE: allowed = wel && !hit;
            K_CHIP:          allowed = wel && (bp == 3'd0);
            K_SRW:           allowed = wel && !(lock && !wp_pin);
            default:         allowed = 1'b0;
        endcase
        verdict.grant  = is_write_kind(kind) && !busy && allowed;
        verdict.reject = is_write_kind(kind) && !verdict.grant;
    end
endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_kind_e  kind,
    input  logic       grant,
    input  logic [7:0] sr_wdata,
    input  logic       op_done,
    output logic [7:0] sr_q
);
    logic       pend_srw_q;
    logic [7:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            pend_srw_q <= 1'b0;
            pend_q     <= '0;
        end else if (sr_q[BIT_BUSY]) begin
            if (op_done) begin
                sr_q[BIT_BUSY] <= 1'b0;
                sr_q[BIT_WEL]  <= 1'b0;
                if (pend_srw_q) begin
                    sr_q[7:2] <= (sr_q[7:2] & ~SR_WMASK[7:2]) | (pend_q[7:2] & SR_WMASK[7:2]);
                end
                pend_srw_q <= 1'b0;
            end
        end else begin
            unique case (kind)
                K_WREN: sr_q[BIT_WEL] <= 1'b1;
                K_WRDI: sr_q[BIT_WEL] <= 1'b0;
                default: begin
                    if (grant) begin
                        sr_q[BIT_BUSY] <= 1'b1;
                        pend_srw_q     <= (kind == K_SRW);
                        pend_q         <= sr_wdata & {6'h3F, 2'b00} | {6'h00, pend_q[1:0]};
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_pin,
    input  logic [7:0]        sr_wdata,
    input  logic              op_done,
    output logic              grant,
    output logic              reject,
    output logic [7:0]        status
);
    cmd_kind_e  kind;
    logic       hit;
    verdict_t   verdict;
    logic [7:0] sr_q;

    assign kind = req_valid ? decode_op(req_op) : K_NONE;

    flash_wp_region #(.ADDR_W(ADDR_W)) u_region (
        .bp   (sr_q[4:2]),
        .addr (req_addr),
        .hit  (hit)
    );

    flash_wp_decide u_decide (
        .kind    (kind),
        .busy    (sr_q[BIT_BUSY]),
        .wel     (sr_q[BIT_WEL]),
        .lock    (sr_q[BIT_LOCK]),
        .bp      (sr_q[4:2]),
        .wp_pin  (wp_pin),
        .hit     (hit),
        .verdict (verdict)
    );

    flash_wp_status u_status (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .grant    (verdict.grant),
        .sr_wdata (sr_wdata),
        .op_done  (op_done),
        .sr_q     (sr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= verdict.grant;
            reject <= verdict.reject;
        end
    end

    assign status = {sr_q[7], 2'b00, sr_q[4:0]};
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk
    import flash_wp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [7:0] req_op,
    input logic       wp_pin,
    input logic       op_done,
    input logic       grant,
    input logic       reject,
    input logic [7:0] status
);
    logic wr_req;
    assign wr_req = req_valid && is_write_kind(decode_op(req_op));

    a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    a_r3_answer_next: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (grant || reject));

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> !grant && !reject);

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_WREN && !status[0] |=> status[1]);

    a_r6_chip_level: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_CHIP && status[4:2] != 3'd0 |=> reject);

    a_r7_lock_pin: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_SRW && status[7] && !wp_pin |=> reject);

    a_r8_reject_keeps_wel: assert property (@(posedge clk) disable iff (rst)
        reject && !$past(status[0]) |-> $stable(status[1]));

    a_r9_grant_busy: assert property (@(posedge clk) disable iff (rst)
        grant |-> status[0]);

    a_r9_busy_rejects: assert property (@(posedge clk) disable iff (rst)
        wr_req && status[0] |=> reject);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (rst)
        status[0] && op_done |=> !status[0] && !status[1]);

    a_r10_bits_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(status[7:2]) |-> $past(status[0] && op_done));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        status[6:5] == 2'b00);
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .wp_pin    (wp_pin),
    .op_done   (op_done),
    .grant     (grant),
    .reject    (reject),
    .status    (status)
);

// File: tb/flash_wp_ctrl_tb_top.sv
module flash_wp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_op = 8'h00;
    logic [19:0] req_addr = '0;
    logic        wp_pin = 1'b1;
    logic [7:0]  sr_wdata = 8'h00;
    logic        op_done = 1'b0;
    logic        grant, reject;
    logic [7:0]  status;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic       m_wel = 0, m_busy = 0, m_lock = 0, m_pend = 0;
    logic [2:0] m_bp = 0;
    logic [7:0] m_pdata = 0;
    logic       e_grant = 0, e_reject = 0;

    always #5 clk = ~clk;

    flash_wp_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp_pin(wp_pin), .sr_wdata(sr_wdata),
        .op_done(op_done), .grant(grant), .reject(reject), .status(status)
    );

    function automatic logic wr_op(input logic [7:0] op);
        return op == 8'h02 || op == 8'h20 || op == 8'hD8 || op == 8'hC7 || op == 8'h01;
    endfunction

    function automatic logic fenced(input logic [2:0] bp, input logic [19:0] a);
        case (bp)
            3'd0: return 1'b0;
            3'd1: return a >= 20'hF0000;
            3'd2: return a >= 20'hE0000;
            3'd3: return a >= 20'hC0000;
            3'd4: return a >= 20'h80000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        return {m_lock, 2'b00, m_bp, m_wel, m_busy};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic ok;
        e_grant = 0; e_reject = 0;
        if (m_busy) begin
            if (req_valid && wr_op(req_op)) e_reject = 1;
            if (op_done) begin
                m_busy = 0; m_wel = 0;
                if (m_pend) begin m_bp = m_pdata[4:2]; m_lock = m_pdata[7]; end
                m_pend = 0;
            end
        end else if (req_valid) begin
            if (req_op == 8'h06) m_wel = 1;
            else if (req_op == 8'h04) m_wel = 0;
            else if (wr_op(req_op)) begin
                case (req_op)
                    8'hC7:   ok = m_wel && m_bp == 0;
                    8'h01:   ok = m_wel && !(m_lock && !wp_pin);
                    default: ok = m_wel && !fenced(m_bp, req_addr);
                endcase
                e_grant = ok; e_reject = !ok;
                if (ok) begin m_busy = 1; m_pend = (req_op == 8'h01); m_pdata = sr_wdata; end
            end
        end
    endtask

    task automatic step(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        check({tag, " grant"}, {7'd0, grant}, {7'd0, e_grant});
        check({tag, " reject"}, {7'd0, reject}, {7'd0, e_reject});
        check({tag, " status"}, status, m_status());
        req_valid = 0; op_done = 0;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [19:0] a, input logic [7:0] d, input string tag);
        req_valid = 1; req_op = op; req_addr = a; sr_wdata = d;
        step(tag);
    endtask

    task automatic done(input string tag);
        op_done = 1;
        step(tag);
    endtask

    function automatic string rand_tag(input logic [7:0] op);
        if (m_busy) return "R9";
        case (op)
            8'h06, 8'h04: return "R2";
            8'hC7: return "R6";
            8'h01: return "R7";
            8'h02, 8'h20, 8'hD8: return "R5";
            default: return "R3";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [7:0] ops [10];
        int unsigned seed;
        ops = '{8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h05, 8'h03, 8'h06};
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", status, 8'h00);
        check("R1 verdicts", {6'd0, grant, reject}, 8'h00);
        rst = 0;
        check("R1 after release", status, 8'h00);

        cmd(8'h06, 0, 0, "R2 set latch");
        cmd(8'h04, 0, 0, "R2 clear latch");
        cmd(8'h02, 20'h00100, 0, "R8 no latch reject");
        cmd(8'h06, 0, 0, "R2 set latch");
        cmd(8'h01, 0, 8'h04, "R7 status write grant");
        step("R10 level not yet applied");
        cmd(8'h06, 0, 0, "R2 ignored while busy");
        cmd(8'h20, 20'h00000, 0, "R9 busy reject");
        done("R10 level applied");
        cmd(8'h06, 0, 0, "R2 set latch");
        cmd(8'h02, 20'hF0000, 0, "R4 fenced edge reject");
        cmd(8'h02, 20'hEFFFF, 0, "R4 below edge grant");
        done("R10 program complete");
        cmd(8'h06, 0, 0, "R2 set latch");
        cmd(8'hC7, 20'h00000, 0, "R6 chip level reject");
        cmd(8'h01, 0, 8'hE0, "R11 write lock and reserved");
        done("R11 reserved read zero");
        cmd(8'h06, 0, 0, "R2 set latch");
        wp_pin = 0;
        cmd(8'h01, 0, 8'h00, "R7 locked reject");
        cmd(8'h05, 0, 0, "R3 other opcode");
        wp_pin = 1;
        cmd(8'h01, 0, 8'h00, "R7 pin high grant");
        done("R10 unlock applied");
        done("R9 idle done ignored");
        cmd(8'h06, 0, 0, "R2 set latch");
        cmd(8'hC7, 20'h12345, 0, "R6 chip grant");
        done("R10 chip complete");

        for (int i = 0; i < 600; i++) begin
            logic [7:0] op;
            op = ops[$urandom_range(0, 9)];
            wp_pin = $urandom_range(0, 1);
            op_done = ($urandom_range(0, 3) == 0);
            sr_wdata = $urandom;
            req_addr = ($urandom_range(0, 1) != 0) ? (20'hFFFFF - 20'($urandom_range(0, 20'h9FFFF))) : 20'($urandom);
            req_valid = ($urandom_range(0, 4) != 0);
            req_op = op;
            step(req_valid ? rand_tag(op) : "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule